// File: doc/BRIEF.md
# Multi-Source Check-In Watchdog

This block is a watchdog counter whose reload is earned jointly by several independent software sources rather than by any single one. Each source owns a reload-request channel and checks in by writing a fixed magic word to it. A programmable channel mask chooses which channels take part. The counter reloads only once every selected channel has checked in since the previous reload. A single silent source therefore lets the counter run out and raise a reset request, even while all the other sources stay healthy.

The counter decrements on a slow tick input, nominally 32.768 kHz, and gives a timeout of (reload value + 1) ticks. The reload value, the channel mask and a pause-on-debug bit are set through a small write port before a start strobe. After start they are locked. The current count, the running state, a one-cycle reset request and a sticky timeout flag are brought out as outputs.

Top module: `chkin_watchdog`

## Requirements
- R1: After reset, `running`, `rst_req` and `timed_out` are 0 and `count` is 0. The reset configuration is reload value 0xFFFFFFFF, mask 0x01 and pause-on-debug off.
- R2: A `start` pulse while idle sets `running` and loads `count` with the reload value on the same clock edge. A `start` pulse while running has no effect on `count`.
- R3: While running, each cycle with `tick` high decrements `count` by one. Before start, ticks leave `count` at 0. With reload value N and no reloads, the (N+1)-th tick after start is the expiring one.
- R4: An expiring tick is a tick that arrives with `count` at 0 and no reload in the same cycle. On an expiring tick, `rst_req` is high for exactly the following cycle and `timed_out` becomes 1 and stays 1 until reset. On that same edge, `count` reloads and all check-ins are cleared.
- R5: A write to address 8+n (n = 0..7) with data 0x6E524635 checks in channel n, but only while running. A write of any other data value, or a write made before start, does not check the channel in.
- R6: The mask register has one bit per channel, and a set bit enables that channel. The counter reloads only when every channel whose mask bit is set has checked in. Check-ins on channels that are not enabled never cause a reload. A mask of 0 never reloads.
- R7: The reload occurs on the clock edge after the edge on which the last required check-in was recorded: `count` returns to the reload value and all check-ins clear together. A check-in written in the reload cycle itself counts toward the next round.
- R8: When a reload and an expiring tick fall in the same cycle, the reload wins. `count` returns to the reload value, no `rst_req` is raised and `timed_out` is unchanged.
- R9: The configuration writes are: address 0 for the reload value (data bits 31:0), and address 1 for the mask (data bits 7:0) and pause-on-debug (data bit 8). These writes take effect only while idle. After start they are ignored.
- R10: With pause-on-debug set, a cycle where `dbg_halt` is high does not decrement `count` even if `tick` is high. With pause-on-debug clear, `dbg_halt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0 reload, 1 config, 8..15 channels) |
| wr_data | input | 32 | Write data |
| start | input | 1 | Start strobe |
| tick | input | 1 | Counter tick enable (slow time base) |
| dbg_halt | input | 1 | Debugger halt indication |
| rst_req | output | 1 | One-cycle reset request on expiry |
| timed_out | output | 1 | Sticky expiry flag |
| running | output | 1 | Counter started |
| count | output | 32 | Current counter value |

## Verification
The two functions that can collide are the final check-in of a round and an expiring tick. The reload decision is made in the cycle after the last check-in is recorded, so the bench first lets the count reach 0 with ticks. It then checks in all enabled channels with the tick held low, and raises the tick exactly in the cycle where the reload is due. It judges the outcome by a reloaded count with no reset request and no change to the sticky flag. It also writes a further check-in in that same cycle and confirms that the check-in carries over into the next round. Random traffic mixes ticks, halts, valid and invalid check-ins and locked configuration writes, against a cycle model built from the requirements.

// File: rtl/chkin_watchdog.sv
module chkin_watchdog #(
  parameter int CHANNELS = 8,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter logic [DATA_W-1:0] MAGIC = 32'h6E524635
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic              tick,
  input  logic              dbg_halt,
  output logic              rst_req,
  output logic              timed_out,
  output logic              running,
  output logic [CNT_W-1:0]  count
);
  localparam int RR_BASE   = 2 ** (ADDR_W - 1);
  localparam int PAUSE_BIT = 8;

  logic [CNT_W-1:0]    reload_val;
  logic [CHANNELS-1:0] mask, flags, hit;
  logic                pause_dbg;

  genvar i;
  generate
    for (i = 0; i < CHANNELS; i++) begin : g_hit
      assign hit[i] = running && wr_en && wr_addr == ADDR_W'(RR_BASE + i) && wr_data == MAGIC;
    end
  endgenerate

  wire cfg_ok   = wr_en && !running;
  wire all_in   = running && (mask != '0) && ((flags & mask) == mask);
  wire tick_act = running && tick && !(pause_dbg && dbg_halt);
  wire expire   = tick_act && count == '0 && !all_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_val <= '1;
      mask       <= CHANNELS'(1);
      pause_dbg  <= 1'b0;
      flags      <= '0;
      running    <= 1'b0;
      count      <= '0;
      rst_req    <= 1'b0;
      timed_out  <= 1'b0;
    end else begin
      rst_req <= expire;
      if (expire) timed_out <= 1'b1;
      if (cfg_ok && wr_addr == ADDR_W'(0)) reload_val <= wr_data[CNT_W-1:0];
      if (cfg_ok && wr_addr == ADDR_W'(1)) begin
        mask      <= wr_data[CHANNELS-1:0];
        pause_dbg <= wr_data[PAUSE_BIT];
      end
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          count   <= reload_val;
        end
      end else if (all_in || expire) begin
        count <= reload_val;
        flags <= hit;
      end else begin
        if (tick_act) count <= count - CNT_W'(1);
        flags <= flags | hit;
      end
    end
  end

  // R2: counter holds zero until started
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> count == '0);

  // R4: reset request always accompanied by the sticky flag
  a_r4_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> timed_out);

  // R4: sticky flag never drops
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |=> timed_out);

  // R3: without a tick or reload the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    running && !tick && !all_in |=> count == $past(count));

  // R7: after a reload only same-cycle check-ins remain
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    all_in |=> flags == $past(hit) && count == $past(reload_val));

  // R8: a reload never raises a reset request
  a_r8_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    all_in |=> !rst_req);

  // R9: configuration locked while running
  a_r9_locked: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(reload_val) && $stable(mask) && $stable(pause_dbg));

  // R10: a paused halt freezes the counter
  a_r10_pause: assert property (@(posedge clk) disable iff (!rst_n)
    running && pause_dbg && dbg_halt && !all_in |=> count == $past(count));
endmodule

// File: tb/chkin_watchdog_test.sv
module chkin_watchdog_test;
  localparam logic [31:0] MAGIC = 32'h6E524635;

  logic clk = 0, rst_n = 0, wr_en = 0, start = 0, tick = 0, dbg_halt = 0;
  logic [3:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic rst_req, timed_out, running;
  logic [31:0] count;

  int vectors = 0, fails = 0, cycles = 0;

  // reference state
  logic [31:0] m_rel, m_cnt;
  logic [7:0]  m_mask, m_flags;
  logic m_pause, m_run, m_req, m_tmo;

  chkin_watchdog uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .tick(tick), .dbg_halt(dbg_halt),
    .rst_req(rst_req), .timed_out(timed_out), .running(running), .count(count));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic m_reset();
    m_rel = '1; m_cnt = 0; m_mask = 8'h01; m_flags = 0;
    m_pause = 0; m_run = 0; m_req = 0; m_tmo = 0;
  endtask

  function automatic logic [7:0] m_hits();
    logic [7:0] h = 0;
    if (m_run && wr_en && wr_addr[3] && wr_data == MAGIC) h[wr_addr[2:0]] = 1'b1;
    return h;
  endfunction

  task automatic m_step();
    logic [7:0] h = m_hits();
    logic all = m_run && m_mask != 0 && (m_flags & m_mask) == m_mask;
    logic ta  = m_run && tick && !(m_pause && dbg_halt);
    logic ex  = ta && m_cnt == 0 && !all;
    logic [31:0] rel_old = m_rel;
    m_req = ex;
    if (ex) m_tmo = 1;
    if (wr_en && !m_run && wr_addr == 0) m_rel = wr_data;
    if (wr_en && !m_run && wr_addr == 1) begin m_mask = wr_data[7:0]; m_pause = wr_data[8]; end
    if (!m_run) begin
      if (start) begin m_run = 1; m_cnt = rel_old; end
    end else if (all || ex) begin
      m_cnt = rel_old; m_flags = h;
    end else begin
      if (ta) m_cnt = m_cnt - 1;
      m_flags = m_flags | h;
    end
  endtask

  task automatic compare(string tag);
    logic bad = 0;
    vectors++;
    if (count !== m_cnt) begin bad = 1; $display("FAIL %s count act=%0d exp=%0d", tag, count, m_cnt); end
    if (rst_req !== m_req) begin bad = 1; $display("FAIL %s rst_req act=%b exp=%b", tag, rst_req, m_req); end
    if (timed_out !== m_tmo) begin bad = 1; $display("FAIL %s timed_out act=%b exp=%b", tag, timed_out, m_tmo); end
    if (running !== m_run) begin bad = 1; $display("FAIL %s running act=%b exp=%b", tag, running, m_run); end
    if (bad) fails++;
  endtask

  task automatic expect_val(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic cyc(string tag, logic we, logic [3:0] a, logic [31:0] d,
                     logic st, logic tk, logic hl);
    wr_en = we; wr_addr = a; wr_data = d; start = st; tick = tk; dbg_halt = hl;
    @(posedge clk);
    m_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; start = 0; tick = 0; dbg_halt = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1; m_reset();
    compare("R1 reset");
  endtask

  task automatic setup(logic [31:0] crv, logic [8:0] cfg);
    cyc("R9 cfg", 1, 0, crv, 0, 0, 0);
    cyc("R9 cfg", 1, 1, {23'd0, cfg}, 0, 0, 0);
    cyc("R2 start", 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();
    expect_val("R1 count", count, 0);
    expect_val("R1 timed_out", {31'd0, timed_out}, 0);
    cyc("R3 pre-start tick", 0, 0, 0, 0, 1, 0);
    cyc("R5 pre-start checkin", 1, 8, MAGIC, 0, 0, 0);

    setup(4, 9'h003);
    expect_val("R2 load", count, 4);
    cyc("R3 tick", 0, 0, 0, 0, 1, 0);
    expect_val("R3 decrement", count, 3);
    cyc("R2 restart ignored", 0, 0, 0, 1, 0, 0);
    expect_val("R2 restart ignored", count, 3);
    // R5 bad value, then ch1 valid; R6 disabled ch2; no reload yet
    cyc("R5 wrong data", 1, 8, MAGIC ^ 1, 0, 0, 0);
    cyc("R5 ch1", 1, 9, MAGIC, 0, 0, 0);
    cyc("R6 ch2 disabled", 1, 10, MAGIC, 0, 1, 0);
    cyc("R6 idle", 0, 0, 0, 0, 0, 0);
    expect_val("R5 no reload", count, 2);
    cyc("R7 ch0", 1, 8, MAGIC, 0, 0, 0);
    cyc("R7 reload", 1, 8, MAGIC, 0, 0, 0);
    expect_val("R7 reload value", count, 4);
    cyc("R7 carry ch1", 1, 9, MAGIC, 0, 0, 0);
    cyc("R7 carried reload", 0, 0, 0, 0, 0, 0);
    expect_val("R7 carried reload", count, 4);
    // R9 locked config, R3/R4 expiry after 5 ticks
    cyc("R9 locked crv", 1, 0, 9, 0, 0, 0);
    cyc("R9 locked mask", 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc("R3 countdown", 0, 0, 0, 0, 1, 0);
    expect_val("R3 at zero", count, 0);
    cyc("R4 expire", 0, 0, 0, 0, 1, 0);
    expect_val("R4 rst_req", {31'd0, rst_req}, 1);
    expect_val("R9 crv kept", count, 4);
    cyc("R4 pulse end", 0, 0, 0, 0, 0, 0);
    expect_val("R4 one cycle", {31'd0, rst_req}, 0);
    expect_val("R4 sticky", {31'd0, timed_out}, 1);
    // R8 collision: count 0, check in both, tick on reload cycle
    for (int k = 0; k < 4; k++) cyc("R8 prep", 0, 0, 0, 0, 1, 0);
    cyc("R8 ch0", 1, 8, MAGIC, 0, 0, 0);
    cyc("R8 ch1", 1, 9, MAGIC, 0, 0, 0);
    cyc("R8 collide", 1, 8, MAGIC, 0, 1, 0);
    expect_val("R8 no rst_req", {31'd0, rst_req}, 0);
    expect_val("R8 reloaded", count, 4);

    // R10 pause on
    do_reset();
    setup(6, 9'h101);
    cyc("R10 halted", 0, 0, 0, 0, 1, 1);
    expect_val("R10 frozen", count, 6);
    cyc("R10 resume", 0, 0, 0, 0, 1, 0);
    expect_val("R10 resume", count, 5);
    do_reset();
    setup(6, 9'h001);
    cyc("R10 no pause", 0, 0, 0, 0, 1, 1);
    expect_val("R10 halt ignored", count, 5);
    // R6 mask zero
    do_reset();
    setup(3, 9'h000);
    for (int k = 0; k < 8; k++) cyc("R6 mask zero", 1, 4'(8 + k), MAGIC, 0, 1, 0);
    expect_val("R6 mask zero expired", {31'd0, timed_out}, 1);

    // random rounds
    for (int r = 0; r < 12; r++) begin
      do_reset();
      setup($urandom_range(25, 0), {1'($urandom_range(1, 0)), 8'($urandom_range(255, 1))});
      for (int k = 0; k < 2500; k++) begin
        int sel = $urandom_range(99, 0);
        logic we = sel < 60;
        logic [3:0] a = (sel < 50) ? 4'(8 + $urandom_range(7, 0)) : 4'($urandom_range(1, 0));
        logic [31:0] d = ($urandom_range(9, 0) < 8) ? MAGIC : $urandom;
        cyc("R6 random", we, a, d, $urandom_range(19, 0) == 0,
            $urandom_range(2, 0) == 0, $urandom_range(4, 0) == 0);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule